// File: doc/BRIEF.md
# Random Bit Stretcher Control

This block is the deterministic expansion stage that sits behind the entropy conditioner of a hardware random number generator. It keeps a 128-bit working value and a 128-bit cipher key. A 256-bit seed from the conditioner loads both of them. After loading, each generation calls an external 128-bit block cipher three times. The block returns the first ciphertext to a consumer and writes the other two back as the next working value and key.

The cipher is not part of the block. It is reached through a request/acknowledge port. The consumer takes words through a valid/ready port that holds one word. A limit counter stops generation after a fixed number of outputs. Generation stays stopped until fresh seed material is absorbed.

Top module: `drbg_rate_ctrl`

## Requirements
- R1: After reset, enc_req_o and rnd_valid_o are low and seed_ready_o is high.
- R2: An accepted seed loads the working value from seed_i[127:0] and the key from seed_i[255:128]. The first cipher request after it carries exactly these two values.
- R3: A generation makes exactly three cipher requests, all under the same key. Their plaintexts are V, V+1 and V+2 (modulo 2^128), where V is the working value.
- R4: The word delivered on rnd_data_o is the ciphertext returned for the first request of the generation.
- R5: The next generation uses the second ciphertext as its working value and the third ciphertext as its key.
- R6: At most MAX_OUTPUTS (511) words are generated per seed. After the last of them, no cipher request is issued until a seed is accepted.
- R7: A seed is accepted only between generations. seed_ready_o is low while a request is pending, a seed offered mid-generation is taken after the third result has been written back, and the generation in flight is not altered.
- R8: Accepting a seed restarts the output count and lifts a stall, so generation resumes.
- R9: Before the first seed is accepted, no cipher request is issued.
- R10: While rnd_valid_o is high and rnd_ready_i is low, rnd_valid_o stays high and rnd_data_o does not change.
- R11: While enc_req_o is high and enc_ack_i is low, the request, plaintext and key stay unchanged.
- R12: No cipher request is issued while an undelivered word is held. A new generation starts only after the previous word has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seed_valid_i | input | 1 | Seed offered |
| seed_i | input | 256 | Seed: high half is the key, low half is the working value |
| seed_ready_o | output | 1 | Seed can be absorbed this cycle |
| enc_req_o | output | 1 | Cipher request |
| enc_pt_o | output | 128 | Cipher plaintext |
| enc_key_o | output | 128 | Cipher key |
| enc_ack_i | input | 1 | Single-cycle cipher acknowledge |
| enc_ct_i | input | 128 | Ciphertext, valid with enc_ack_i |
| rnd_valid_o | output | 1 | Random word available |
| rnd_data_o | output | 128 | Random word |
| rnd_ready_i | input | 1 | Consumer takes the word |

## Verification
The cipher model is a keyed, non-linear mixing function. Any mix-up of plaintext and key, or of the first, second and third results, therefore produces a different word and exposes which value went to the wrong place. Generations run with zero and with multi-cycle acknowledge latency, so that requests must be held stable while they wait. One seed places the working value just below 2^128, which checks that the plus-one steps wrap to zero. Further runs cover a seed offered in the middle of a generation, a consumer that holds back ready, and a full run of 511 words followed by a stall and its release, which separate the seed-absorption, hold and limit rules from the main data path.

// File: rtl/drbg_pkg.sv
package drbg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN0 = 2'd1,
    PH_RUN1 = 2'd2,
    PH_RUN2 = 2'd3
  } phase_e;
endpackage

// File: rtl/drbg_phase_seq.sv
module drbg_phase_seq
  import drbg_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   ack_i,
  output phase_e phase_o,
  output logic   cap0_o,
  output logic   cap1_o,
  output logic   fin_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start_i) phase_d = PH_RUN0;
      PH_RUN0: if (ack_i)   phase_d = PH_RUN1;
      PH_RUN1: if (ack_i)   phase_d = PH_RUN2;
      PH_RUN2: if (ack_i)   phase_d = PH_IDLE;
      default:              phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;
  assign cap0_o  = ack_i && (phase_q == PH_RUN0);
  assign cap1_o  = ack_i && (phase_q == PH_RUN1);
  assign fin_o   = ack_i && (phase_q == PH_RUN2);
endmodule

// File: rtl/drbg_reseed_cnt.sv
module drbg_reseed_cnt #(
  parameter int unsigned MAX_OUTPUTS = 511,
  localparam int unsigned CNT_W = $clog2(MAX_OUTPUTS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic incr_i,
  output logic stall_o
);
  localparam logic [CNT_W-1:0] CntMax = CNT_W'(MAX_OUTPUTS);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clear_i)                     cnt_q <= '0;
    else if (incr_i && (cnt_q != CntMax)) cnt_q <= cnt_q + 1'b1;
  end

  assign stall_o = (cnt_q == CntMax);
endmodule

// File: rtl/drbg_out_hold.sv
module drbg_out_hold #(
  parameter int unsigned W = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  logic         valid_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
    end else if (valid_q && ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/drbg_rate_ctrl.sv
module drbg_rate_ctrl
  import drbg_pkg::*;
#(
  parameter int unsigned W           = 128,
  parameter int unsigned MAX_OUTPUTS = 511,
  localparam int unsigned SEED_W     = 2 * W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seed_valid_i,
  input  logic [SEED_W-1:0] seed_i,
  output logic              seed_ready_o,
  output logic              enc_req_o,
  output logic [W-1:0]      enc_pt_o,
  output logic [W-1:0]      enc_key_o,
  input  logic              enc_ack_i,
  input  logic [W-1:0]      enc_ct_i,
  output logic              rnd_valid_o,
  output logic [W-1:0]      rnd_data_o,
  input  logic              rnd_ready_i
);
  phase_e       phase;
  logic         cap0, cap1, fin, start, accept, stall, idle, seeded_q;
  logic [W-1:0] state_q, key_q, res0_q, res1_q;

  assign idle         = (phase == PH_IDLE);
  assign seed_ready_o = idle;
  assign accept       = seed_valid_i && idle;
  // a pending seed wins over starting a generation
  assign start        = idle && seeded_q && !stall && !rnd_valid_o && !seed_valid_i;

  drbg_phase_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .ack_i   (enc_ack_i),
    .phase_o (phase),
    .cap0_o  (cap0),
    .cap1_o  (cap1),
    .fin_o   (fin)
  );

  drbg_reseed_cnt #(.MAX_OUTPUTS(MAX_OUTPUTS)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .incr_i  (fin),
    .stall_o (stall)
  );

  drbg_out_hold #(.W(W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (fin),
    .data_i  (res0_q),
    .ready_i (rnd_ready_i),
    .valid_o (rnd_valid_o),
    .data_o  (rnd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seeded_q <= 1'b0;
      state_q  <= '0;
      key_q    <= '0;
      res0_q   <= '0;
      res1_q   <= '0;
    end else if (accept) begin
      seeded_q <= 1'b1;
      state_q  <= seed_i[W-1:0];
      key_q    <= seed_i[SEED_W-1:W];
    end else if (cap0) begin
      res0_q  <= enc_ct_i;
      state_q <= state_q + 1'b1;
    end else if (cap1) begin
      res1_q  <= enc_ct_i;
      state_q <= state_q + 1'b1;
    end else if (fin) begin
      state_q <= res1_q;
      key_q   <= enc_ct_i;
    end
  end

  assign enc_req_o = !idle;
  assign enc_pt_o  = state_q;
  assign enc_key_o = key_q;
endmodule

// File: rtl/drbg_rate_ctrl_chk.sv
module drbg_rate_ctrl_chk #(
  parameter int unsigned W           = 128,
  parameter int unsigned MAX_OUTPUTS = 511,
  localparam int unsigned CW         = $clog2(MAX_OUTPUTS + 2)
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         seed_valid_i,
  input logic         seed_ready_o,
  input logic         enc_req_o,
  input logic [W-1:0] enc_pt_o,
  input logic [W-1:0] enc_key_o,
  input logic         enc_ack_i,
  input logic         rnd_valid_o,
  input logic [W-1:0] rnd_data_o,
  input logic         rnd_ready_i
);
  logic          seeded_q, valid_q;
  logic [CW-1:0] made_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seeded_q <= 1'b0;
      valid_q  <= 1'b0;
      made_q   <= '0;
    end else begin
      valid_q <= rnd_valid_o;
      if (seed_valid_i && seed_ready_o) begin
        seeded_q <= 1'b1;
        made_q   <= '0;
      end else if (rnd_valid_o && !valid_q) begin
        made_q <= made_q + 1'b1;
      end
    end
  end

  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_req_o && !enc_ack_i |=> enc_req_o && $stable(enc_pt_o) && $stable(enc_key_o));

  p_out_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rnd_valid_o && !rnd_ready_i |=> rnd_valid_o && $stable(rnd_data_o));

  p_no_req_full_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rnd_valid_o |-> !enc_req_o);

  p_seed_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_req_o |-> !seed_ready_o);

  p_unseeded_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seeded_q |-> !enc_req_o);

  p_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    made_q <= CW'(MAX_OUTPUTS));
endmodule

bind drbg_rate_ctrl drbg_rate_ctrl_chk #(.W(W), .MAX_OUTPUTS(MAX_OUTPUTS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .seed_valid_i (seed_valid_i),
  .seed_ready_o (seed_ready_o),
  .enc_req_o    (enc_req_o),
  .enc_pt_o     (enc_pt_o),
  .enc_key_o    (enc_key_o),
  .enc_ack_i    (enc_ack_i),
  .rnd_valid_o  (rnd_valid_o),
  .rnd_data_o   (rnd_data_o),
  .rnd_ready_i  (rnd_ready_i)
);

// File: tb/drbg_rate_ctrl_tb_top.sv
`timescale 1ns/1ps
module drbg_rate_ctrl_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         seed_valid_i = 1'b0;
  logic [255:0] seed_i = '0;
  logic         seed_ready_o;
  logic         enc_req_o;
  logic [127:0] enc_pt_o, enc_key_o;
  logic         enc_ack_i = 1'b0;
  logic [127:0] enc_ct_i = '0;
  logic         rnd_valid_o;
  logic [127:0] rnd_data_o;
  logic         rnd_ready_i = 1'b0;

  int checks = 0, errors = 0;
  int lat = 0, wait_cnt = 0;
  int n_calls = 0, n_out = 0, req_seen = 0, cycles = 0;
  logic [127:0] log_pt [16];
  logic [127:0] log_key[16];
  logic [127:0] cur_s, cur_k;

  always #5 clk_i = ~clk_i;

  drbg_rate_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .seed_valid_i(seed_valid_i), .seed_i(seed_i), .seed_ready_o(seed_ready_o),
    .enc_req_o(enc_req_o), .enc_pt_o(enc_pt_o), .enc_key_o(enc_key_o),
    .enc_ack_i(enc_ack_i), .enc_ct_i(enc_ct_i),
    .rnd_valid_o(rnd_valid_o), .rnd_data_o(rnd_data_o), .rnd_ready_i(rnd_ready_i)
  );

  function automatic logic [127:0] ciph(input logic [127:0] p, input logic [127:0] k);
    logic [127:0] x;
    x = p ^ {k[63:0], k[127:64]};
    x = {x[114:0], x[127:115]} + k + 128'h0123456789abcdef_fedcba9876543210;
    return x ^ {x[95:0], x[127:96]};
  endfunction

  // cipher model and monitors, all on the falling edge
  always @(negedge clk_i) begin
    cycles++;
    if (!rst_ni) begin
      enc_ack_i = 1'b0;
      wait_cnt = 0;
    end else begin
      if (enc_req_o) req_seen++;
      if (rnd_valid_o && rnd_ready_i) n_out++;
      if (enc_ack_i) begin
        enc_ack_i = 1'b0;
        wait_cnt = 0;
      end else if (enc_req_o) begin
        if (wait_cnt >= lat) begin
          enc_ack_i = 1'b1;
          enc_ct_i = ciph(enc_pt_o, enc_key_o);
          if (n_calls < 16) begin
            log_pt[n_calls]  = enc_pt_o;
            log_key[n_calls] = enc_key_o;
          end
          n_calls++;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic give_seed(input logic [127:0] s, input logic [127:0] k);
    @(negedge clk_i);
    seed_i = {k, s};
    seed_valid_i = 1'b1;
    while (!seed_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    seed_valid_i = 1'b0;
    cur_s = s;
    cur_k = k;
  endtask

  task automatic wait_valid();
    int t = 0;
    while (!rnd_valid_o && t < 2000) begin @(negedge clk_i); t++; end
  endtask

  // checks one generation against the tracked state, pops it and advances the model
  task automatic check_gen(input string tag, input int hold);
    logic [127:0] o, ns, nk, held;
    o  = ciph(cur_s, cur_k);
    ns = ciph(cur_s + 128'd1, cur_k);
    nk = ciph(cur_s + 128'd2, cur_k);
    wait_valid();
    chk(rnd_valid_o, {tag, " R4 valid"}, 128'(rnd_valid_o), 128'd1);
    chk(n_calls == 3, {tag, " R3 call count"}, 128'(n_calls), 128'd3);
    for (int i = 0; i < 3; i++) begin
      chk(log_pt[i] == cur_s + 128'(i), {tag, " R3 plaintext"}, log_pt[i], cur_s + 128'(i));
      chk(log_key[i] == cur_k, {tag, " R3 key"}, log_key[i], cur_k);
    end
    chk(rnd_data_o == o, {tag, " R4 word"}, rnd_data_o, o);
    held = rnd_data_o;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk_i);
      chk(rnd_valid_o && rnd_data_o == held && !enc_req_o, {tag, " R10 R12 hold"}, rnd_data_o, held);
    end
    rnd_ready_i = 1'b1;
    @(negedge clk_i);
    rnd_ready_i = 1'b0;
    n_calls = 0;
    cur_s = ns;
    cur_k = nk;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(!enc_req_o && !rnd_valid_o && seed_ready_o, "R1 reset outputs",
        {125'd0, enc_req_o, rnd_valid_o, seed_ready_o}, 128'd1);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk_i);
    chk(req_seen == 0 && !rnd_valid_o, "R9 no request before seed", 128'(req_seen), 128'd0);
  endtask

  task automatic t_basic();
    lat = 0;
    n_calls = 0;
    give_seed(128'h00112233445566778899aabbccddeeff, 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0);
    chk(1'b1, "R2 seed split checked in first generation", 0, 0);
    check_gen("R2 gen0", 0);
    check_gen("R5 gen1", 0);
    lat = 3;
    check_gen("R5 R11 gen2 slow", 4);
    check_gen("R5 R11 gen3 slow", 0);
  endtask

  task automatic t_wrap();
    lat = 1;
    wait_valid();
    rnd_ready_i = 1'b1;
    @(negedge clk_i);
    rnd_ready_i = 1'b0;
    while (enc_req_o || enc_ack_i) @(negedge clk_i);
    wait_valid();
    // seed while the word is pending, then drain the old one
    give_seed({128{1'b1}} - 128'd1, 128'hdeadbeef00000000cafef00d12345678);
    rnd_ready_i = 1'b1;
    @(negedge clk_i);
    rnd_ready_i = 1'b0;
    n_calls = 0;
    check_gen("R3 R8 wrap", 0);
    check_gen("R5 after wrap", 0);
  endtask

  task automatic t_mid_seed();
    logic [127:0] s2, k2;
    int t = 0;
    s2 = 128'h13579bdf2468ace013579bdf2468ace0;
    k2 = 128'hfedcba98765432100123456789abcdef;
    lat = 4;
    while (!enc_req_o && t < 100) begin @(negedge clk_i); t++; end
    seed_i = {k2, s2};
    seed_valid_i = 1'b1;
    @(negedge clk_i);
    chk(!seed_ready_o && enc_req_o, "R7 seed held off mid generation", 128'(seed_ready_o), 128'd0);
    while (!seed_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    seed_valid_i = 1'b0;
    check_gen("R7 in-flight unchanged", 0);
    cur_s = s2;
    cur_k = k2;
    check_gen("R7 R8 new seed used", 0);
  endtask

  task automatic t_limit();
    int t = 0, base_req;
    lat = 0;
    wait_valid();
    give_seed(128'h1, 128'h2);
    rnd_ready_i = 1'b1;
    @(negedge clk_i);
    n_out = 0;
    n_calls = 0;
    while (n_out < 511 && t < 30000) begin @(negedge clk_i); t++; end
    rnd_ready_i = 1'b1;
    repeat (40) @(negedge clk_i);
    chk(n_out == 511, "R6 outputs per seed", 128'(n_out), 128'd511);
    chk(n_calls == 3 * 511, "R6 R3 cipher calls per seed", 128'(n_calls), 128'(3 * 511));
    base_req = req_seen;
    repeat (30) @(negedge clk_i);
    chk(req_seen == base_req && !rnd_valid_o, "R6 stalled", 128'(req_seen - base_req), 128'd0);
    rnd_ready_i = 1'b0;
    n_calls = 0;
    give_seed(128'h77, 128'h88);
    check_gen("R8 resume after stall", 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_wrap();
    t_mid_seed();
    t_limit();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule